// File: doc/BRIEF.md
# Indexed Gather/Scatter Sequencer

This block carries out a single vector indexed load (gather) or indexed store (scatter) one step per clock. Each element's memory address is a scalar base plus a per-element offset taken from an offset vector. The offset has the same width as the data element. Elements can be skipped under an optional mask. Each element can also carry several consecutive fields (a segment), and each field lands in its own register group.

The operation runs in phases. First a probe pass asks the memory port for permission on the whole byte span of every active element. Only when every probe succeeds does the data pass begin. A load then zeroes the inactive tail of each destination field. Because of this ordering, a fault leaves both memory and the registers untouched. Loaded data goes out through a register-file write port. Store data comes in through a register-file read port. The memory port answers in the same cycle it is asked: read data and the probe fault are combinational responses.

Top module: `gs_indexed_seq`

## Requirements
- R1: The address of field 0 of element i is `base` plus offset i, with the sum wrapping modulo 2^AW. Offset i is the low element-width bits of `offs_vec[i*ELEN +: ELEN]`. It is sign-extended for stores and for signed loads (`sgn_ld`=1), and zero-extended for unsigned loads.
- R2: With `use_mask`=1, an element whose `mask_vec` bit is 0 gets no probe, no read or write request, and no register write.
- R3: Field k of element i uses address (element address + k << `msz`) and register index i + k*`vlmax`. The segment has `nf_m1`+1 fields.
- R4: The probe pass comes first. It takes one cycle per element in ascending order. Each active element gets one request with `mem_op`=0 and `mem_size` = (`nf_m1`+1) << `msz` bytes. No read (`mem_op`=1) or write (`mem_op`=2) is issued before the pass ends.
- R5: A probe answered with `mem_fault`=1 ends the operation on the next cycle with `done`=1, `fault`=1 and `fault_idx` set to that element. No memory write or register write happens.
- R6: After a load's data pass, for each field k in ascending order, register indexes vl..vlmax-1 (plus k*`vlmax`) are written with zero, one per cycle. Nothing is written when vl equals vlmax.
- R7: With `vl`=0, the cycle after `start` has `done`=1 with no request and no register write.
- R8: A load reads (1 << `msz`) bytes, little-endian. The value is sign-extended (`sgn_ld`=1) or zero-extended up to the element width 8 << `sew`. Bits above the element width are zero.
- R9: A store writes (1 << `msz`) bytes taken from the low bytes of the register element. `mem_wdata` bits above the access width are zero, and a store never writes the register file.
- R10: If `msz` > `sew`, the operation is rejected. The next cycle shows `done`=1 and `illegal`=1, with no request and no register write.
- R11: The data pass runs elements in ascending order, with fields ascending inside each element, one cycle per field. `done` is a one-cycle pulse in the cycle after the last step. Out of reset, `done`, `mem_req` and `rf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| is_store | input | 1 | 1 = scatter, 0 = gather |
| sgn_ld | input | 1 | Load: signed extension and signed offsets |
| use_mask | input | 1 | Apply `mask_vec` |
| sew | input | 2 | Element width code: 0=8, 1=16, 2=32 bits |
| msz | input | 2 | Access width code: 0=1, 1=2, 2=4 bytes |
| nf_m1 | input | NFW | Field count minus one |
| vl | input | CW | Active length |
| vlmax | input | CW | Maximum length (1..VLMAX, >= vl) |
| base | input | AW | Scalar base address |
| offs_vec | input | VLMAX*ELEN | Offset elements, element i at bits i*ELEN |
| mask_vec | input | VLMAX | Element mask |
| mem_req | output | 1 | Memory request valid |
| mem_op | output | 2 | 0 probe, 1 read, 2 write |
| mem_addr | output | AW | Request address |
| mem_size | output | SZW | Request span in bytes |
| mem_wdata | output | ELEN | Store data |
| mem_rdata | input | ELEN | Read data, same cycle |
| mem_fault | input | 1 | Probe refused, same cycle |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | RW | Register write index |
| rf_wdata | output | ELEN | Register write data |
| rf_raddr | output | RW | Register read index |
| rf_rdata | input | ELEN | Register read data, same cycle |
| done | output | 1 | Completion pulse |
| fault | output | 1 | With `done`: probe fault |
| fault_idx | output | IW | With `fault`: faulting element |
| illegal | output | 1 | With `done`: width combination rejected |

## Verification
The first probe request appears in the cycle right after the clock edge that samples `start`. Each later step appears exactly one cycle after the one before it: one cycle per element during probing, one per field during the data pass, and one per tail slot during clearing. `done` follows the last step by one cycle; on reject, on `vl`=0, or after a fault, it comes one cycle after `start` or after the faulting probe. The bench turns each operation into a list with one expected port picture per cycle, built from the requirements before `start` is raised. It then compares the list one entry per falling edge, starting with the cycle after the sampling edge. Any extra or missing cycle therefore shows up as a shifted mismatch.

// File: rtl/gs_pkg.sv
// Shared types for the indexed gather/scatter sequencer.
package gs_pkg;
    typedef enum logic [1:0] {
        MOP_PROBE = 2'd0,
        MOP_READ  = 2'd1,
        MOP_WRITE = 2'd2
    } mem_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROBE,
        S_XFER,
        S_CLEAR,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/gs_addr_gen.sv
// Address generator: extends an offset element from its element width
// (signed or unsigned), adds it to the base and adds the field offset
// k << msz. The sum wraps modulo 2^AW.
// Assumes AW <= ELEN and that sew selects a width no wider than ELEN.
module gs_addr_gen #(
    parameter int AW   = 16,
    parameter int ELEN = 32,
    parameter int NFW  = 3
) (
    input  logic [AW-1:0]   base,
    input  logic [ELEN-1:0] offset,
    input  logic [1:0]      sew,
    input  logic            off_signed,
    input  logic [NFW-1:0]  fld,
    input  logic [1:0]      msz,
    output logic [AW-1:0]   ea
);
    logic [ELEN-1:0] ext;
    logic [AW-1:0]   fld_off;
    int              ow;
    logic            sbit;

    // Extend the element-width offset to ELEN bits.
    always_comb begin
        ow   = 8 << sew;
        sbit = off_signed & offset[ow-1];
        for (int b = 0; b < ELEN; b++) begin
            ext[b] = (b < ow) ? offset[b] : sbit;
        end
    end

    // Field offset and final wrapping sum.
    always_comb begin
        fld_off = AW'(fld) << msz;
        ea      = base + ext[AW-1:0] + fld_off;
    end
endmodule

// File: rtl/gs_elem_fmt.sv
// Element formatter: widens a loaded access-width value to the element
// width (sign or zero), clearing bits above the element; trims store data
// to the access width.
// Assumes msz <= sew (illegal combinations are filtered upstream).
module gs_elem_fmt #(
    parameter int ELEN = 32
) (
    input  logic [ELEN-1:0] rdata,
    input  logic [ELEN-1:0] rf_rdata,
    input  logic [1:0]      msz,
    input  logic [1:0]      sew,
    input  logic            sgn,
    output logic [ELEN-1:0] ld_val,
    output logic [ELEN-1:0] st_val
);
    int   mw;
    int   ew;
    logic msb;

    // Bitwise select between data, extension and zero.
    always_comb begin
        mw  = 8 << msz;
        ew  = 8 << sew;
        msb = rdata[mw-1];
        for (int b = 0; b < ELEN; b++) begin
            if (b < mw)      ld_val[b] = rdata[b];
            else if (b < ew) ld_val[b] = sgn & msb;
            else             ld_val[b] = 1'b0;
            st_val[b] = (b < mw) ? rf_rdata[b] : 1'b0;
        end
    end
endmodule

// File: rtl/gs_indexed_seq.sv
// Indexed gather/scatter sequencer. Runs a probe pass over all active
// elements, then a data pass over every (element, field), then, for loads,
// a tail-clear pass. One step per clock.
// Assumes: memory and register-file reads answer in the same cycle;
// offs_vec, mask_vec and rf contents are stable during an operation;
// 1 <= vlmax <= VLMAX and vl <= vlmax; start is only raised while idle.
module gs_indexed_seq
    import gs_pkg::*;
#(
    parameter int AW    = 16,
    parameter int ELEN  = 32,
    parameter int VLMAX = 8,
    parameter int NFMAX = 8,
    localparam int IW   = $clog2(VLMAX),
    localparam int CW   = $clog2(VLMAX + 1),
    localparam int NFW  = $clog2(NFMAX),
    localparam int RW   = $clog2(VLMAX * NFMAX),
    localparam int SZW  = $clog2(NFMAX * ELEN / 8 + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  is_store,
    input  logic                  sgn_ld,
    input  logic                  use_mask,
    input  logic [1:0]            sew,
    input  logic [1:0]            msz,
    input  logic [NFW-1:0]        nf_m1,
    input  logic [CW-1:0]         vl,
    input  logic [CW-1:0]         vlmax,
    input  logic [AW-1:0]         base,
    input  logic [VLMAX*ELEN-1:0] offs_vec,
    input  logic [VLMAX-1:0]      mask_vec,
    output logic                  mem_req,
    output logic [1:0]            mem_op,
    output logic [AW-1:0]         mem_addr,
    output logic [SZW-1:0]        mem_size,
    output logic [ELEN-1:0]       mem_wdata,
    input  logic [ELEN-1:0]       mem_rdata,
    input  logic                  mem_fault,
    output logic                  rf_we,
    output logic [RW-1:0]         rf_waddr,
    output logic [ELEN-1:0]       rf_wdata,
    output logic [RW-1:0]         rf_raddr,
    input  logic [ELEN-1:0]       rf_rdata,
    output logic                  done,
    output logic                  fault,
    output logic [IW-1:0]         fault_idx,
    output logic                  illegal
);
    seq_state_e      state;
    logic            st_q, sg_q, msk_q;
    logic [1:0]      sew_q, msz_q;
    logic [NFW-1:0]  nfm1_q;
    logic [CW-1:0]   vl_q, vlmax_q;
    logic [AW-1:0]   base_q;
    logic [CW-1:0]   el_q;
    logic [NFW-1:0]  fld_q;
    logic            fault_q, illegal_q;
    logic [IW-1:0]   fidx_q;

    logic [IW-1:0]   cur;
    logic            active, last_el, last_fld, last_slot;
    logic [RW-1:0]   ridx;
    logic [SZW-1:0]  probe_sz;
    logic [NFW-1:0]  ag_fld;
    logic [ELEN-1:0] ld_val, st_val;
    mem_op_e         op_c;

    // Current element decode.
    always_comb begin
        cur       = el_q[IW-1:0];
        active    = !msk_q || mask_vec[cur];
        last_el   = (el_q == vl_q - CW'(1));
        last_slot = (el_q == vlmax_q - CW'(1));
        last_fld  = (fld_q == nfm1_q);
        ridx      = RW'(el_q) + RW'(fld_q) * RW'(vlmax_q);
        probe_sz  = (SZW'(nfm1_q) + SZW'(1)) << msz_q;
        ag_fld    = (state == S_PROBE) ? '0 : fld_q;
    end

    gs_addr_gen #(.AW(AW), .ELEN(ELEN), .NFW(NFW)) u_addr (
        .base       (base_q),
        .offset     (offs_vec[cur*ELEN +: ELEN]),
        .sew        (sew_q),
        .off_signed (st_q | sg_q),
        .fld        (ag_fld),
        .msz        (msz_q),
        .ea         (mem_addr)
    );

    gs_elem_fmt #(.ELEN(ELEN)) u_fmt (
        .rdata    (mem_rdata),
        .rf_rdata (rf_rdata),
        .msz      (msz_q),
        .sew      (sew_q),
        .sgn      (sg_q),
        .ld_val   (ld_val),
        .st_val   (st_val)
    );

    // Request and register-write outputs per phase.
    always_comb begin
        mem_req  = 1'b0;
        op_c     = MOP_PROBE;
        mem_size = '0;
        rf_we    = 1'b0;
        rf_wdata = '0;
        unique case (state)
            S_PROBE: begin
                mem_req  = active;
                mem_size = probe_sz;
            end
            S_XFER: begin
                mem_req  = active;
                op_c     = st_q ? MOP_WRITE : MOP_READ;
                mem_size = SZW'(1) << msz_q;
                rf_we    = active && !st_q;
                rf_wdata = ld_val;
            end
            S_CLEAR: rf_we = 1'b1;
            default: ;
        endcase
    end

    assign mem_op    = op_c;
    assign mem_wdata = st_val;
    assign rf_waddr  = ridx;
    assign rf_raddr  = ridx;
    assign done      = (state == S_DONE);
    assign fault     = done && fault_q;
    assign illegal   = done && illegal_q;
    assign fault_idx = fidx_q;

    // Phase sequencing and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            st_q      <= 1'b0;
            sg_q      <= 1'b0;
            msk_q     <= 1'b0;
            sew_q     <= '0;
            msz_q     <= '0;
            nfm1_q    <= '0;
            vl_q      <= '0;
            vlmax_q   <= '0;
            base_q    <= '0;
            el_q      <= '0;
            fld_q     <= '0;
            fault_q   <= 1'b0;
            illegal_q <= 1'b0;
            fidx_q    <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    st_q      <= is_store;
                    sg_q      <= sgn_ld;
                    msk_q     <= use_mask;
                    sew_q     <= sew;
                    msz_q     <= msz;
                    nfm1_q    <= nf_m1;
                    vl_q      <= vl;
                    vlmax_q   <= vlmax;
                    base_q    <= base;
                    el_q      <= '0;
                    fld_q     <= '0;
                    fault_q   <= 1'b0;
                    fidx_q    <= '0;
                    illegal_q <= (msz > sew);
                    if (msz > sew || vl == '0) state <= S_DONE;
                    else                       state <= S_PROBE;
                end
                S_PROBE: begin
                    if (active && mem_fault) begin
                        fault_q <= 1'b1;
                        fidx_q  <= cur;
                        state   <= S_DONE;
                    end else if (last_el) begin
                        el_q  <= '0;
                        state <= S_XFER;
                    end else begin
                        el_q <= el_q + CW'(1);
                    end
                end
                S_XFER: begin
                    if (!last_fld) begin
                        fld_q <= fld_q + NFW'(1);
                    end else begin
                        fld_q <= '0;
                        if (!last_el) begin
                            el_q <= el_q + CW'(1);
                        end else if (st_q || vl_q == vlmax_q) begin
                            state <= S_DONE;
                        end else begin
                            el_q  <= vl_q;
                            state <= S_CLEAR;
                        end
                    end
                end
                S_CLEAR: begin
                    if (last_slot) begin
                        el_q <= vl_q;
                        if (last_fld) state <= S_DONE;
                        else          fld_q <= fld_q + NFW'(1);
                    end else begin
                        el_q <= el_q + CW'(1);
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Masked-off elements never reach the memory port.
    assert_mask_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && msk_q) |-> mask_vec[cur]);

    // A fault recorded in this operation forbids any later write.
    assert_no_write_after_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == 2'd2) |-> !fault_q);

    // Stores never touch the register file.
    assert_store_no_rf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !st_q);

    // A rejected operation issues nothing in the cycle before its done.
    assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!$past(mem_req) && !$past(rf_we)));

    // Completion is a single-cycle pulse with the ports quiet.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && !rf_we));
endmodule

// File: tb/test_gs_indexed_seq.sv
module test_gs_indexed_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, ELEN = 32, VLMAX = 8, NFMAX = 8;
    localparam int IW = 3, CW = 4, NFW = 3, RW = 6, SZW = 6;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic is_store = 0, sgn_ld = 0, use_mask = 0;
    logic [1:0] sew = 0, msz = 0;
    logic [NFW-1:0] nf_m1 = 0;
    logic [CW-1:0] vl = 0, vlmax = 1;
    logic [AW-1:0] base = 0;
    logic [31:0] offs [VLMAX];
    logic [VLMAX*ELEN-1:0] offs_vec;
    logic [VLMAX-1:0] mask_vec = 0;
    logic mem_req, mem_fault, rf_we, done, fault, illegal;
    logic [1:0] mem_op;
    logic [AW-1:0] mem_addr;
    logic [SZW-1:0] mem_size;
    logic [ELEN-1:0] mem_wdata, mem_rdata, rf_wdata, rf_rdata;
    logic [RW-1:0] rf_waddr, rf_raddr;
    logic [IW-1:0] fault_idx;

    logic [7:0]  mem [256];
    logic [31:0] rf  [64];
    int vecs = 0, fails = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb for (int i = 0; i < VLMAX; i++) offs_vec[i*ELEN +: ELEN] = offs[i];

    function automatic bit in_hole(logic [15:0] a, int n);
        for (int b = 0; b < n; b++)
            if (((a + 16'(b)) & 16'hFF00) == 16'hE000) return 1'b1;
        return 1'b0;
    endfunction

    assign mem_rdata = {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                        mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
    assign mem_fault = mem_req && mem_op == 2'd0 && in_hole(mem_addr, int'(mem_size));
    assign rf_rdata  = rf[rf_raddr];

    always @(posedge clk) begin
        if (mem_req && mem_op == 2'd2)
            for (int b = 0; b < int'(mem_size); b++) mem[mem_addr[7:0] + 8'(b)] <= mem_wdata[8*b +: 8];
        if (rf_we) rf[rf_waddr] <= rf_wdata;
    end

    gs_indexed_seq i_gs_indexed_seq (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R11 watchdog: got %0d cycles, expected under 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    typedef struct {
        bit req; logic [1:0] op; logic [15:0] addr; int size; logic [31:0] wd;
        bit we; int idx; logic [31:0] rd; bit dn; bit flt; bit ill; int fidx;
    } ev_t;
    ev_t q[$];

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [15:0] m_ea(int i, int k);
        logic [31:0] o = offs[i];
        int w = 8 << sew;
        if (w < 32) begin
            o = o & ((32'h1 << w) - 1);
            if ((is_store || sgn_ld) && o[w-1]) o = o | ~((32'h1 << w) - 1);
        end
        return base + o[15:0] + 16'(k << msz);
    endfunction

    function automatic logic [31:0] m_load(logic [15:0] a);
        int n = 1 << msz, ew = 8 << sew;
        logic [31:0] v = 0;
        for (int b = 0; b < n; b++) v = v | (32'(mem[a[7:0] + 8'(b)]) << (8*b));
        if (sgn_ld && n < 4 && v[8*n-1]) v = v | ~((32'h1 << (8*n)) - 1);
        if (ew < 32) v = v & ((32'h1 << ew) - 1);
        return v;
    endfunction

    // Build the per-cycle expectation list for the configured operation.
    task automatic model();
        ev_t e, z;
        int nf = int'(nf_m1) + 1, fi = -1;
        z = '{default: 0};
        q.delete();
        if (msz > sew) begin e = z; e.dn = 1; e.ill = 1; q.push_back(e); return; end
        if (vl == 0) begin e = z; e.dn = 1; q.push_back(e); return; end
        for (int i = 0; i < int'(vl); i++) begin
            e = z;
            if (!use_mask || mask_vec[i]) begin
                e.req = 1; e.op = 0; e.addr = m_ea(i, 0); e.size = nf << msz;
                if (in_hole(e.addr, e.size)) fi = i;
            end
            q.push_back(e);
            if (fi >= 0) break;
        end
        if (fi >= 0) begin e = z; e.dn = 1; e.flt = 1; e.fidx = fi; q.push_back(e); return; end
        for (int i = 0; i < int'(vl); i++)
            for (int k = 0; k < nf; k++) begin
                e = z;
                if (!use_mask || mask_vec[i]) begin
                    e.req = 1; e.addr = m_ea(i, k); e.size = 1 << msz;
                    if (is_store) begin
                        e.op = 2;
                        e.wd = (msz == 2) ? rf[i + k*int'(vlmax)]
                             : rf[i + k*int'(vlmax)] & ((32'h1 << (8 << msz)) - 1);
                    end else begin
                        e.op = 1; e.we = 1; e.idx = i + k*int'(vlmax); e.rd = m_load(e.addr);
                    end
                end
                q.push_back(e);
            end
        if (!is_store)
            for (int k = 0; k < nf; k++)
                for (int j = int'(vl); j < int'(vlmax); j++) begin
                    e = z; e.we = 1; e.idx = j + k*int'(vlmax); e.rd = 0; q.push_back(e);
                end
        e = z; e.dn = 1; q.push_back(e);
    endtask

    task automatic run(string tag);
        ev_t e;
        model();
        @(negedge clk); start = 1;
        for (int n = 0; n < q.size(); n++) begin
            @(negedge clk);
            start = 0;
            e = q[n];
            chk(tag, "mem_req", 32'(mem_req), 32'(e.req));
            if (e.req) begin
                chk(tag, "mem_op", 32'(mem_op), 32'(e.op));
                chk({tag, " R1"}, "mem_addr", 32'(mem_addr), 32'(e.addr));
                chk({tag, " R4"}, "mem_size", 32'(mem_size), 32'(e.size));
                if (e.op == 2) chk({tag, " R9"}, "mem_wdata", mem_wdata, e.wd);
            end
            chk(tag, "rf_we", 32'(rf_we), 32'(e.we));
            if (e.we) begin
                chk({tag, " R3"}, "rf_waddr", 32'(rf_waddr), 32'(e.idx));
                chk({tag, " R8"}, "rf_wdata", rf_wdata, e.rd);
            end
            chk({tag, " R11"}, "done", 32'(done), 32'(e.dn));
            if (e.dn) begin
                chk({tag, " R5"}, "fault", 32'(fault), 32'(e.flt));
                chk({tag, " R10"}, "illegal", 32'(illegal), 32'(e.ill));
                if (e.flt) chk({tag, " R5"}, "fault_idx", 32'(fault_idx), 32'(e.fidx));
            end
        end
    endtask

    task automatic cfg(bit st, bit sg, bit mk, logic [7:0] m, logic [1:0] s, logic [1:0] z,
                       int nf, int l, int lm, logic [15:0] b);
        is_store = st; sgn_ld = sg; use_mask = mk; mask_vec = m; sew = s; msz = z;
        nf_m1 = NFW'(nf - 1); vl = CW'(l); vlmax = CW'(lm); base = b;
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'(a * 37 + 5);
        for (int j = 0; j < 64; j++) rf[j] = 32'h8000_0000 + 32'(j) * 32'h0103_0507;
        for (int i = 0; i < VLMAX; i++) offs[i] = 32'(i * 4);
        repeat (3) @(negedge clk);
        chk("R11 reset", "done", 32'(done), 0);
        chk("R11 reset", "mem_req", 32'(mem_req), 0);
        chk("R11 reset", "rf_we", 32'(rf_we), 0);
        rst_n = 1;

        // R1 R8 R6: signed byte load into word elements, negative offset
        offs[0] = 0; offs[1] = 5; offs[2] = 32'hFFFF_FFFC; offs[3] = 32'h20;
        cfg(0, 1, 0, 8'h00, 2, 0, 1, 4, 8, 16'h0010); run("R1 R8 R6 signed-load");
        // R1 R8: unsigned byte elements, offset upper bits ignored
        offs[0] = 32'hABCD_EFF0; offs[1] = 32'h1234_5681; offs[2] = 32'h0000_0002;
        cfg(0, 0, 0, 8'h00, 0, 0, 1, 3, 8, 16'h0100); run("R1 R8 unsigned-load");
        // R2 R3 R6: masked three-field halfword segment load
        for (int i = 0; i < VLMAX; i++) offs[i] = 32'(i * 12);
        offs[0] = 32'h0000_FFF0;
        cfg(0, 1, 1, 8'b1011_0101, 1, 1, 3, 6, 8, 16'h0040); run("R2 R3 R6 segment-load");
        // R9 R3 R2: masked two-field halfword store from word elements
        for (int i = 0; i < VLMAX; i++) offs[i] = 32'(i * 8);
        cfg(1, 0, 1, 8'b0001_1011, 2, 1, 2, 5, 6, 16'h0080); run("R9 R3 R2 store");
        // R9: byte store of byte elements, eight fields
        cfg(1, 0, 0, 8'h00, 0, 0, 8, 2, 2, 16'h00C0); run("R9 byte-store");
        // R5: load faults at element 2, nothing written
        offs[0] = 0; offs[1] = 4; offs[2] = 32'h10; offs[3] = 8;
        cfg(0, 0, 0, 8'h00, 2, 2, 1, 4, 8, 16'hDFF0); run("R5 load-fault");
        // R5: store whose segment span crosses into the hole at element 1
        offs[0] = 32'hFFFF_FFE0; offs[1] = 0; offs[2] = 4;
        cfg(1, 0, 0, 8'h00, 2, 1, 4, 3, 4, 16'hDFFC); run("R5 store-fault");
        // R7: zero active length, load and store
        cfg(0, 1, 0, 8'h00, 2, 0, 2, 0, 8, 16'h0000); run("R7 vl0-load");
        cfg(1, 0, 0, 8'h00, 2, 0, 1, 0, 8, 16'h0000); run("R7 vl0-store");
        // R10: access wider than element
        cfg(0, 0, 0, 8'h00, 0, 1, 1, 4, 8, 16'h0000); run("R10 illegal-a");
        cfg(1, 0, 0, 8'h00, 1, 2, 1, 4, 8, 16'h0000); run("R10 illegal-b");
        // R1 R6: address wrap, vl equal to vlmax (no tail)
        offs[0] = 32'h10; offs[1] = 32'hFFFF_0014;
        cfg(0, 0, 0, 8'h00, 2, 2, 1, 2, 2, 16'hFFF8); run("R1 R6 wrap");
        // R2 R6: every element masked off, tail still cleared
        cfg(0, 0, 1, 8'h00, 1, 0, 2, 3, 5, 16'h0020); run("R2 R6 all-masked");
        // R11: full-length unmasked word load, ordering
        for (int i = 0; i < VLMAX; i++) offs[i] = 32'((7 - i) * 4);
        cfg(0, 1, 0, 8'h00, 2, 2, 2, 8, 8, 16'h0000); run("R11 order");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule